// File: doc/BRIEF.md
# Register-Controlled Barrel Shifter with Carry Flag

This block shifts or rotates a 32-bit word by an amount taken from the low byte of a second operand. Four kinds of operation are offered: logical left, logical right, arithmetic right and rotate right. Amounts from 32 up to 255 have defined results. The shifted word and the candidate carry are formed combinationally in the same cycle as the inputs.

A carry flag register holds the current carry. When the set-flags input is high, the flag takes the candidate carry at the next clock edge. When set-flags is low, the flag keeps its value. The candidate carry depends on the kind of operation and on where the amount falls: zero, 1 to 31, exactly 32, or above 32. For rotates, a non-zero multiple of 32 is a case of its own. An amount of zero leaves both the word and the carry untouched.

Top module: `bsh_top`

## Requirements
- R1: Only bits 7:0 of `amt_src` form the shift amount n. Bits 31:8 have no effect on `result` or `carry_next`.
- R2: The operation kind is encoded on `kind` as 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right and 2'b11 rotate right. For logical left and logical right with n of 32 or more, `result` is zero.
- R3: For arithmetic right with n of 32 or more, every bit of `result` equals bit 31 of `src_data`, and `carry_next` is bit 31 of `src_data`.
- R4: When n is zero, `result` equals `src_data` and `carry_next` equals `carry_flag`. This holds for every kind.
- R5: For logical left, the carry depends on n as follows:
  - n from 1 to 31: `result` is the input shifted left with zero fill, and `carry_next` is input bit 32-n.
  - n equal to 32: `carry_next` is input bit 0.
  - n above 32: `carry_next` is 0.
- R6: For logical right, the carry depends on n as follows:
  - n from 1 to 31: `result` is the input shifted right with zero fill, and `carry_next` is input bit n-1.
  - n equal to 32: `carry_next` is input bit 31.
  - n above 32: `carry_next` is 0.
- R7: For arithmetic right with n from 1 to 31, `result` is the input shifted right with copies of bit 31 filling from the top, and `carry_next` is input bit n-1.
- R8: Rotate right uses m = n mod 32.
  - m non-zero: `result` is the input rotated right by m, and `carry_next` is input bit m-1.
  - m zero with n non-zero: `result` equals the input, and `carry_next` is input bit 31.
- R9: `carry_flag` is 0 after a synchronous reset. It takes `carry_next` at a rising clock edge when `set_flags` is 1, and holds its value when `set_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | 32 | Word to shift or rotate |
| amt_src | input | 32 | Amount operand; only bits 7:0 are used |
| kind | input | 2 | Operation kind (00 LSL, 01 LSR, 10 ASR, 11 ROR) |
| set_flags | input | 1 | When high, the carry flag loads `carry_next` at the clock edge |
| result | output | 32 | Shifted or rotated word |
| carry_next | output | 1 | Carry the operation would produce |
| carry_flag | output | 1 | Registered carry flag |

## Verification
Two functions can fall in the same cycle: the combinational shift, whose carry may select the current flag, and the flag update. A zero-amount operation with set-flags high makes the new carry equal to the old flag while the flag is being written. The bench provokes this with the flag first set to 1 and then cleared to 0. It judges `result` and `carry_next` mid-cycle, and `carry_flag` just after the edge, against a bench-side model of the flag. Runs of operations with set-flags low follow operations that would change the carry, to confirm that the flag holds.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned AMT_W  = 8;
    localparam int unsigned LOG_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    // Decoded amount classes shared by datapath and carry picker
    typedef struct packed {
        logic             amt_zero;   // full byte is zero
        logic             ge_width;   // amount >= DATA_W
        logic             eq_width;   // amount == DATA_W
        logic             over_width; // amount >  DATA_W
        logic [LOG_W-1:0] low;        // amount mod DATA_W
        logic             low_zero;   // low field is zero
    } amt_info_t;

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction
endpackage

// File: rtl/bsh_amt_dec.sv
module bsh_amt_dec
    import bsh_pkg::*;
(
    input  logic [AMT_W-1:0] amt,
    output amt_info_t        info
);
    localparam logic [AMT_W-1:0] WIDTH_VAL = AMT_W'(DATA_W);

    always_comb begin
        info.amt_zero   = (amt == '0);
        info.ge_width   = |amt[AMT_W-1:LOG_W];
        info.eq_width   = (amt == WIDTH_VAL);
        info.over_width = info.ge_width & ~info.eq_width;
        info.low        = amt[LOG_W-1:0];
        info.low_zero   = (amt[LOG_W-1:0] == '0);
    end
endmodule

// File: rtl/bsh_stage_shift.sv
module bsh_stage_shift
    import bsh_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  shift_kind_e       kind,
    input  amt_info_t         info,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] stage [LOG_W+1];
    logic              fill;
    logic              is_rot;
    logic [DATA_W-1:0] shifted;

    // Left shifts run through the right shifter on the reversed word
    assign stage[0] = (kind == SH_LSL) ? bit_rev(src) : src;
    assign fill     = (kind == SH_ASR) ? src[DATA_W-1] : 1'b0;
    assign is_rot   = (kind == SH_ROR);

    for (genvar s = 0; s < LOG_W; s++) begin : g_stage
        localparam int unsigned SH = 1 << s;
        logic [DATA_W-1:0] moved;
        always_comb begin
            if (is_rot) begin
                moved = {stage[s][SH-1:0], stage[s][DATA_W-1:SH]};
            end else begin
                moved = {{SH{fill}}, stage[s][DATA_W-1:SH]};
            end
        end
        assign stage[s+1] = info.low[s] ? moved : stage[s];
    end

    assign shifted = (kind == SH_LSL) ? bit_rev(stage[LOG_W]) : stage[LOG_W];

    always_comb begin
        if (is_rot || !info.ge_width) begin
            value = shifted;
        end else if (kind == SH_ASR) begin
            value = {DATA_W{src[DATA_W-1]}};
        end else begin
            value = '0;
        end
    end
endmodule

// File: rtl/bsh_carry_pick.sv
module bsh_carry_pick
    import bsh_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  shift_kind_e       kind,
    input  amt_info_t         info,
    input  logic              cur_carry,
    output logic              carry
);
    logic [DATA_W-1:0] oriented;
    logic [LOG_W-1:0]  idx;

    assign oriented = (kind == SH_LSL) ? bit_rev(src) : src;
    assign idx      = info.low - LOG_W'(1);

    always_comb begin
        if (info.amt_zero) begin
            carry = cur_carry;
        end else begin
            unique case (kind)
                SH_LSL, SH_LSR: begin
                    if (info.over_width)    carry = 1'b0;
                    else if (info.eq_width) carry = oriented[DATA_W-1];
                    else                    carry = oriented[idx];
                end
                SH_ASR: begin
                    if (info.ge_width) carry = src[DATA_W-1];
                    else               carry = src[idx];
                end
                default: begin
                    if (info.low_zero) carry = src[DATA_W-1];
                    else               carry = src[idx];
                end
            endcase
        end
    end
endmodule

// File: rtl/bsh_top.sv
module bsh_top
    import bsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] amt_src,
    input  logic [1:0]        kind,
    input  logic              set_flags,
    output logic [DATA_W-1:0] result,
    output logic              carry_next,
    output logic              carry_flag
);
    amt_info_t   info;
    shift_kind_e kind_e;
    logic        unused_amt_hi;

    assign kind_e        = shift_kind_e'(kind);
    // R1: upper amount bits are deliberately dropped
    assign unused_amt_hi = ^amt_src[DATA_W-1:AMT_W];

    bsh_amt_dec u_dec (
        .amt  (amt_src[AMT_W-1:0]),
        .info (info)
    );

    bsh_stage_shift u_shift (
        .src   (src_data),
        .kind  (kind_e),
        .info  (info),
        .value (result)
    );

    bsh_carry_pick u_carry (
        .src       (src_data),
        .kind      (kind_e),
        .info      (info),
        .cur_carry (carry_flag),
        .carry     (carry_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_flag <= 1'b0;
        end else if (set_flags) begin
            carry_flag <= carry_next;
        end
    end
endmodule

// File: rtl/bsh_checker.sv
module bsh_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] src_data,
    input logic [31:0] amt_src,
    input logic [1:0]  kind,
    input logic        set_flags,
    input logic [31:0] result,
    input logic        carry_next,
    input logic        carry_flag
);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable(carry_flag));

    // R9
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (carry_flag == $past(carry_next)));

    // R4
    zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (amt_src[7:0] == 8'd0) |-> (result == src_data && carry_next == carry_flag));

    // R2
    wide_logical_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (kind[1] == 1'b0 && amt_src[7:0] >= 8'd32) |-> (result == 32'd0));

    // R3
    wide_asr_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b10 && amt_src[7:0] >= 8'd32)
            |-> (result == {32{src_data[31]}} && carry_next == src_data[31]));

    // R8
    rot_multiple_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b11 && amt_src[4:0] == 5'd0 && amt_src[7:5] != 3'd0)
            |-> (result == src_data && carry_next == src_data[31]));
endmodule

bind bsh_top bsh_checker u_chk (.*);

// File: tb/bsh_top_tb.sv
module bsh_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_data = '0;
    logic [31:0] amt_src = '0;
    logic [1:0]  kind = '0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        carry_next;
    logic        carry_flag;

    int   n_checks = 0;
    int   n_errors = 0;
    logic mflag = 1'b0;
    bit   finished = 0;

    always #10 clk = ~clk;

    bsh_top u_dut (.*);

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check1(input string tag, input string what,
                          input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Model built from the requirement text
    task automatic ref_model(input logic [31:0] d, input logic [31:0] a,
                             input logic [1:0] k, input logic cin,
                             output logic [31:0] r, output logic c);
        int n;
        int m;
        n = int'(a[7:0]);
        m = n % 32;
        r = d;
        c = cin;
        if (n != 0) begin
            case (k)
                2'b00: begin
                    if (n < 32)       begin r = d << n; c = d[32-n]; end
                    else if (n == 32) begin r = '0; c = d[0]; end
                    else              begin r = '0; c = 1'b0; end
                end
                2'b01: begin
                    if (n < 32)       begin r = d >> n; c = d[n-1]; end
                    else if (n == 32) begin r = '0; c = d[31]; end
                    else              begin r = '0; c = 1'b0; end
                end
                2'b10: begin
                    if (n < 32) begin r = 32'($signed(d) >>> n); c = d[n-1]; end
                    else        begin r = {32{d[31]}}; c = d[31]; end
                end
                default: begin
                    if (m == 0) begin r = d; c = d[31]; end
                    else begin r = (d >> m) | (d << (32 - m)); c = d[m-1]; end
                end
            endcase
        end
    endtask

    task automatic do_op(input logic [31:0] d, input logic [31:0] a,
                         input logic [1:0] k, input logic sf, input string tag);
        logic [31:0] er;
        logic        ec;
        @(negedge clk);
        src_data  = d;
        amt_src   = a;
        kind      = k;
        set_flags = sf;
        ref_model(d, a, k, mflag, er, ec);
        #2;
        check32(tag, "result", result, er);
        check1(tag, "carry_next", carry_next, ec);
        @(posedge clk);
        #1;
        if (sf) mflag = ec;
        check1(tag, "carry_flag", carry_flag, mflag);
        set_flags = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check1("R9 reset", "carry_flag", carry_flag, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        mflag = 1'b0;
    endtask

    task automatic t_lsl();
        for (int n = 1; n < 32; n += 5) do_op(32'h8000_0001 ^ (32'h1 << (32 - n)), n, 2'b00, 1'b1, "R5 lsl range");
        do_op(32'hA5A5_F00F, 32'd31, 2'b00, 1'b1, "R5 lsl 31");
        do_op(32'h0000_0001, 32'd32, 2'b00, 1'b1, "R5 lsl 32 bit0");
        do_op(32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1, "R2 R5 lsl 33");
        do_op(32'hFFFF_FFFF, 32'd255, 2'b00, 1'b1, "R2 lsl 255");
    endtask

    task automatic t_lsr();
        for (int n = 1; n < 32; n += 6) do_op(32'h1234_5678 | (32'h1 << (n - 1)), n, 2'b01, 1'b1, "R6 lsr range");
        do_op(32'h8000_0000, 32'd32, 2'b01, 1'b1, "R6 lsr 32 bit31");
        do_op(32'hFFFF_FFFF, 32'd40, 2'b01, 1'b1, "R2 R6 lsr 40");
    endtask

    task automatic t_asr();
        do_op(32'h8000_0000, 32'd4, 2'b10, 1'b1, "R7 asr neg");
        do_op(32'h7000_0008, 32'd4, 2'b10, 1'b1, "R7 asr pos carry");
        do_op(32'hF000_0000, 32'd31, 2'b10, 1'b1, "R7 asr 31");
        do_op(32'h8000_0000, 32'd32, 2'b10, 1'b1, "R3 asr 32 neg");
        do_op(32'h7FFF_FFFF, 32'd200, 2'b10, 1'b1, "R3 asr 200 pos");
    endtask

    task automatic t_ror();
        do_op(32'h0000_00F1, 32'd4, 2'b11, 1'b1, "R8 ror 4");
        do_op(32'h8000_0001, 32'd1, 2'b11, 1'b1, "R8 ror 1");
        do_op(32'h1234_5678, 32'd36, 2'b11, 1'b1, "R8 ror 36");
        do_op(32'h8000_0000, 32'd32, 2'b11, 1'b1, "R8 ror 32");
        do_op(32'h0000_0001, 32'd64, 2'b11, 1'b1, "R8 ror 64");
        do_op(32'hC000_0000, 32'd224, 2'b11, 1'b1, "R8 ror 224");
    endtask

    task automatic t_zero();
        do_op(32'h0000_0001, 32'd1, 2'b01, 1'b1, "R4 prep set");
        for (int k = 0; k < 4; k++) do_op(32'hDEAD_BEEF, 32'd0, 2'(k), 1'b1, "R4 zero flag1");
        do_op(32'h0000_0002, 32'd1, 2'b01, 1'b1, "R4 prep clear");
        for (int k = 0; k < 4; k++) do_op(32'hDEAD_BEEF, 32'h0000_0100, 2'(k), 1'b1, "R4 R1 zero flag0");
    endtask

    task automatic t_upper_bits();
        do_op(32'h0000_0010, 32'hFFFF_FF04, 2'b01, 1'b1, "R1 hi bits lsr4");
        do_op(32'h0000_0003, 32'h8000_0002, 2'b00, 1'b1, "R1 hi bits lsl2");
        do_op(32'h8765_4321, 32'h0001_0008, 2'b11, 1'b1, "R1 hi bits ror8");
    endtask

    task automatic t_flag_hold();
        do_op(32'h0000_0001, 32'd1, 2'b01, 1'b1, "R9 load 1");
        do_op(32'h0000_0002, 32'd1, 2'b01, 1'b0, "R9 hold vs 0");
        do_op(32'h0000_0000, 32'd33, 2'b00, 1'b0, "R9 hold vs 0 wide");
        do_op(32'h0000_0000, 32'd1, 2'b01, 1'b1, "R9 load 0");
        do_op(32'h8000_0000, 32'd32, 2'b11, 1'b0, "R9 hold vs 1");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_lsl();
        t_lsr();
        t_asr();
        t_ror();
        t_zero();
        t_upper_bits();
        t_flag_hold();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule